// File: doc/BRIEF.md
# Trusted Module Command/Response Register Interface

This block is the device side of a byte-wide register window through which a host hands a command to a trusted module and collects its reply. A front end, typically an I2C register-access slave, presents single-byte reads and writes with an 8-bit register offset. The block decodes a status register, a burst-count register, a command push port, a response pop port and a four-byte identity window. Behind these registers it runs the lifecycle of one command: idle, ready, receiving, executing and complete.

The host writes commandReady to claim the interface, then pushes command bytes. The block takes the command length from a big-endian 32-bit field in bytes 2 to 5 of the header and keeps `expect` high until that many bytes have arrived. A go write starts an execution stub. After a fixed delay the stub presents the command bytes back as the response. `dataAvail` and the active-low interrupt then stay asserted until the host has popped every response byte. A responseRetry write rewinds the response, and a commandReady write abandons the work in progress from any state.

Top module: `tmri_regif`

## Requirements
- R1: After reset the block is idle, the status register reads 0x80 and `irq_n` is high.
- R2: Status layout is valid = bit 7 (always 1), commandReady = bit 6, dataAvail = bit 4, expect = bit 3. Bits 5, 2, 1 and 0 read as 0. Each read returns its byte with `rd_valid` one cycle after `rd_en`.
- R3: A status write with bit 6 set moves the block to ready from any state (idle, receiving, executing, complete). It discards the partial command and any pending execution. In ready the status reads 0xC0.
- R4: A command-port (offset 0x20) write in ready stores byte 0 and enters receiving, where the status reads 0x88. A command-port write in idle is ignored.
- R5: Bytes 2..5 form a big-endian length, clamped to the range 6 to BUF_DEPTH. Expect stays set until that many bytes are held, then clears. Further command-port writes are ignored.
- R6: A status write with bit 5 set starts execution only in receiving with expect clear. Otherwise it is ignored.
- R7: EXEC_DELAY cycles after go, dataAvail sets. The response has the command's length and repeats its bytes in order.
- R8: Each read at offset 0x40 returns the next response byte. dataAvail clears after the last one. A read there with dataAvail clear returns 0xFF and changes nothing.
- R9: A status write with bit 1 set in the complete state restarts the response at byte 0. In any other state it has no effect.
- R10: Offset 0x01 reads the next transfer allowance: min(BURST_MAX, BUF_DEPTH) in ready. While receiving it reads min(BURST_MAX, bytes left to the target), where the target is BUF_DEPTH until the header is complete. While complete it reads min(BURST_MAX, unread response bytes). Otherwise it reads 0.
- R11: Offsets 0x60..0x63 read 0x50, 0x10, 0xFE and REV_ID. Unmapped offsets read 0x00.
- R12: `irq_n` is low exactly when dataAvail was set in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| irq_n | output | 1 | Active-low level interrupt on dataAvail |

## Verification
The bench goes after the handshake edges. A go issued while bytes are still owed must be refused; a design that accepts it would run a truncated command and report dataAvail early. A short declared length is raised to the header size, and an oversized one is capped at the buffer depth; without these clamps expect would never clear, or bytes would overwrite the buffer. Other attacks: an abort during execution must not let a late completion raise dataAvail; responseRetry must replay from byte 0 rather than continue; and an extra push after completion or a pop from an empty response must leave the response untouched. Each of these errors shows up as a wrong status byte, interrupt level or response byte.

// File: rtl/tmri_pkg.sv
package tmri_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READY, ST_RECV, ST_EXEC, ST_DONE
  } tmri_state_e;

  localparam logic [7:0] OFS_STATUS = 8'h00;
  localparam logic [7:0] OFS_BURST  = 8'h01;
  localparam logic [7:0] OFS_CMD    = 8'h20;
  localparam logic [7:0] OFS_RSP    = 8'h40;
  localparam logic [7:0] OFS_ID0    = 8'h60;
  localparam logic [7:0] OFS_ID1    = 8'h61;
  localparam logic [7:0] OFS_ID2    = 8'h62;
  localparam logic [7:0] OFS_ID3    = 8'h63;

  localparam int BIT_RDY   = 6;
  localparam int BIT_GO    = 5;
  localparam int BIT_RETRY = 1;

  localparam int HDR_LEN = 6;
endpackage

// File: rtl/tmri_buf.sv
module tmri_buf #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wbyte,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rbyte
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wbyte;
    rbyte <= mem[raddr];
  end
endmodule

// File: rtl/tmri_exec.sv
module tmri_exec #(
  parameter int DELAY = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cancel,
  output logic done
);
  localparam int CW = $clog2(DELAY + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign done = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst || cancel) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(DELAY - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/tmri_regif.sv
module tmri_regif
  import tmri_pkg::*;
#(
  parameter int         BUF_DEPTH  = 64,
  parameter int         BURST_MAX  = 32,
  parameter int         EXEC_DELAY = 16,
  parameter logic [7:0] REV_ID     = 8'h01
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  output logic       irq_n
);
  localparam int AW = $clog2(BUF_DEPTH);
  localparam int CW = AW + 1;

  tmri_state_e   state_q;
  logic [CW-1:0] wcnt_q, rsp_len_q, rd_ptr_q;
  logic [31:0]   len_q;
  logic [7:0]    byte_q, mem_byte;
  logic          sel_mem_q;

  // command length target, clamped into the buffer
  logic [CW-1:0] len_eff, target, room;
  always_comb begin
    if (len_q > 32'(BUF_DEPTH))    len_eff = CW'(BUF_DEPTH);
    else if (len_q < 32'(HDR_LEN)) len_eff = CW'(HDR_LEN);
    else                           len_eff = len_q[CW-1:0];
  end

  logic hdr_done, expect_b, data_avail;
  assign hdr_done   = wcnt_q >= CW'(HDR_LEN);
  assign target     = hdr_done ? len_eff : CW'(BUF_DEPTH);
  assign expect_b   = (state_q == ST_RECV) && (!hdr_done || (wcnt_q < len_eff));
  assign data_avail = (state_q == ST_DONE) && (rd_ptr_q < rsp_len_q);

  // write decode
  logic wr_sts, wr_cmd, abort, go_ok, retry, push, pop, exec_done;
  assign wr_sts = wr_en && (addr == OFS_STATUS);
  assign wr_cmd = wr_en && (addr == OFS_CMD);
  assign abort  = wr_sts && wdata[BIT_RDY];
  assign go_ok  = wr_sts && !wdata[BIT_RDY] && wdata[BIT_GO] &&
                  (state_q == ST_RECV) && !expect_b;
  assign retry  = wr_sts && !wdata[BIT_RDY] && wdata[BIT_RETRY] &&
                  (state_q == ST_DONE);
  assign push   = wr_cmd && ((state_q == ST_READY) || expect_b);
  assign pop    = rd_en && (addr == OFS_RSP) && data_avail && !retry;

  tmri_buf #(.DEPTH(BUF_DEPTH), .AW(AW)) u_buf (
    .clk   (clk),
    .we    (push),
    .waddr ((state_q == ST_READY) ? '0 : wcnt_q[AW-1:0]),
    .wbyte (wdata),
    .raddr (rd_ptr_q[AW-1:0]),
    .rbyte (mem_byte)
  );

  tmri_exec #(.DELAY(EXEC_DELAY)) u_exec (
    .clk    (clk),
    .rst    (rst),
    .start  (go_ok),
    .cancel (abort),
    .done   (exec_done)
  );

  // lifecycle state machine
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      wcnt_q    <= '0;
      len_q     <= '0;
      rsp_len_q <= '0;
      rd_ptr_q  <= '0;
    end else if (abort) begin
      state_q  <= ST_READY;
      wcnt_q   <= '0;
      len_q    <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push) begin
        if (state_q == ST_READY) begin
          state_q <= ST_RECV;
          wcnt_q  <= CW'(1);
          len_q   <= '0;
        end else begin
          wcnt_q <= wcnt_q + 1'b1;
          if (wcnt_q >= CW'(2) && wcnt_q < CW'(HDR_LEN))
            len_q <= {len_q[23:0], wdata};
        end
      end
      if (go_ok) begin
        state_q   <= ST_EXEC;
        rsp_len_q <= wcnt_q;
      end
      if (state_q == ST_EXEC && exec_done) begin
        state_q  <= ST_DONE;
        rd_ptr_q <= '0;
      end
      if (retry)    rd_ptr_q <= '0;
      else if (pop) rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  // transfer allowance
  always_comb begin
    case (state_q)
      ST_READY: room = CW'(BUF_DEPTH);
      ST_RECV:  room = expect_b ? (target - wcnt_q) : '0;
      ST_DONE:  room = rsp_len_q - rd_ptr_q;
      default:  room = '0;
    endcase
  end

  logic [7:0] stat_byte, burst_byte;
  assign stat_byte  = {1'b1, state_q == ST_READY, 1'b0, data_avail, expect_b, 3'b000};
  assign burst_byte = (32'(room) > 32'(BURST_MAX)) ? 8'(BURST_MAX) : 8'(room);

  // registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      sel_mem_q <= 1'b0;
      byte_q    <= '0;
      irq_n     <= 1'b1;
    end else begin
      rd_valid  <= rd_en;
      sel_mem_q <= pop;
      irq_n     <= !data_avail;
      case (addr)
        OFS_STATUS: byte_q <= stat_byte;
        OFS_BURST:  byte_q <= burst_byte;
        OFS_RSP:    byte_q <= 8'hFF;
        OFS_ID0:    byte_q <= 8'h50;
        OFS_ID1:    byte_q <= 8'h10;
        OFS_ID2:    byte_q <= 8'hFE;
        OFS_ID3:    byte_q <= REV_ID;
        default:    byte_q <= 8'h00;
      endcase
    end
  end

  assign rd_data = sel_mem_q ? mem_byte : byte_q;

  // assertions
  logic in_exec;
  assign in_exec = (state_q == ST_EXEC);

  p_abort_any_r3: assert property (@(posedge clk) disable iff (rst)
    abort |=> (state_q == ST_READY) && (wcnt_q == '0));

  p_push_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && state_q == ST_RECV && !expect_b) |=> $stable(wcnt_q));

  p_go_from_recv_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(in_exec) |-> $past(state_q == ST_RECV));

  p_empty_pop_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_RSP && !data_avail && !wr_en) |=>
      (rd_data == 8'hFF) && rd_valid && $stable(rd_ptr_q));

  p_irq_source_r12: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> $past(state_q == ST_DONE));

  p_status_low_bits_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_STATUS) |=> (rd_data[2:0] == 3'b000) && !rd_data[5]);
endmodule

// File: tb/tmri_regif_tb_top.sv
module tmri_regif_tb_top;
  localparam int DEPTH = 64;
  localparam int DLY   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rd_data;
  logic rd_valid, irq_n;

  always #2.5 clk = ~clk;

  tmri_regif #(.BUF_DEPTH(DEPTH), .BURST_MAX(32), .EXEC_DELAY(DLY), .REV_ID(8'h07)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid), .irq_n(irq_n)
  );

  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] cmd[64];

  // scoreboard monitor
  always @(negedge clk) begin
    if (rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected read data act=%02h exp=none", rd_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_data !== e) begin
          failures++;
          $display("FAIL %s act=%02h exp=%02h", t, rd_data, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_n !== e) begin
      failures++;
      $display("FAIL %s irq_n act=%0b exp=%0b", t, irq_n, e);
    end
  endtask

  bit finished = 0;

  initial begin
    #(5 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd(8'h00, 8'h80, "R1 status after reset");
    chk_irq(1'b1, "R1");
    // R11 identity and unmapped
    rd(8'h60, 8'h50, "R11 id0");
    rd(8'h61, 8'h10, "R11 id1");
    rd(8'h62, 8'hFE, "R11 id2");
    rd(8'h63, 8'h07, "R11 rev");
    rd(8'h10, 8'h00, "R11 unmapped");
    rd(8'h01, 8'h00, "R10 burst idle");
    // R4 push in idle ignored
    wr(8'h20, 8'h55);
    rd(8'h00, 8'h80, "R4 push in idle ignored");
    // R3 claim
    wr(8'h00, 8'h40);
    rd(8'h00, 8'hC0, "R3 ready status");
    rd(8'h01, 8'd32, "R10 burst ready");
    wr(8'h00, 8'h02);
    rd(8'h00, 8'hC0, "R9 retry in ready ignored");
    // 10-byte command
    cmd[0] = 8'h80; cmd[1] = 8'h01; cmd[2] = 8'h00; cmd[3] = 8'h00;
    cmd[4] = 8'h00; cmd[5] = 8'h0A; cmd[6] = 8'h11; cmd[7] = 8'h22;
    cmd[8] = 8'h33; cmd[9] = 8'h44;
    wr(8'h20, cmd[0]);
    rd(8'h00, 8'h88, "R4 receiving status");
    for (int i = 1; i < 6; i++) wr(8'h20, cmd[i]);
    rd(8'h01, 8'd4, "R10 burst to declared length");
    wr(8'h20, cmd[6]); wr(8'h20, cmd[7]);
    wr(8'h00, 8'h20);
    rd(8'h00, 8'h88, "R6 early go ignored");
    wr(8'h20, cmd[8]); wr(8'h20, cmd[9]);
    rd(8'h00, 8'h80, "R5 expect cleared");
    wr(8'h20, 8'h99);
    wr(8'h00, 8'h20);
    rd(8'h00, 8'h80, "R7 executing no data yet");
    idle(DLY + 10);
    rd(8'h00, 8'h90, "R7 dataAvail set");
    chk_irq(1'b0, "R12 asserted");
    rd(8'h01, 8'd10, "R10 burst response");
    for (int i = 0; i < 4; i++) rd(8'h40, cmd[i], "R8 partial pop");
    wr(8'h00, 8'h02);
    for (int i = 0; i < 10; i++) rd(8'h40, cmd[i], "R9 replay from start");
    rd(8'h00, 8'h80, "R8 dataAvail cleared");
    idle(1);
    chk_irq(1'b1, "R12 released");
    rd(8'h40, 8'hFF, "R8 empty pop");
    rd(8'h00, 8'h80, "R8 empty pop no state change");
    // abort while receiving
    wr(8'h00, 8'h40);
    wr(8'h20, 8'h80); wr(8'h20, 8'h01); wr(8'h20, 8'h00);
    wr(8'h00, 8'h40);
    rd(8'h00, 8'hC0, "R3 abort while receiving");
    // short length clamps to header size, then abort in execution
    wr(8'h20, 8'h80); wr(8'h20, 8'h01);
    wr(8'h20, 8'h00); wr(8'h20, 8'h00); wr(8'h20, 8'h00);
    rd(8'h00, 8'h88, "R5 header incomplete");
    wr(8'h20, 8'h03);
    rd(8'h00, 8'h80, "R5 short length clamped");
    wr(8'h00, 8'h20);
    idle(3);
    wr(8'h00, 8'h40);
    idle(DLY + 10);
    rd(8'h00, 8'hC0, "R3 abort during execution");
    chk_irq(1'b1, "R3 no late interrupt");
    // oversize length clamps to buffer depth
    cmd[0] = 8'h80; cmd[1] = 8'h02; cmd[2] = 8'h00; cmd[3] = 8'h00;
    cmd[4] = 8'h01; cmd[5] = 8'h00;
    for (int i = 6; i < DEPTH; i++) cmd[i] = 8'(i * 3 + 1);
    for (int i = 0; i < DEPTH - 1; i++) wr(8'h20, cmd[i]);
    rd(8'h00, 8'h88, "R5 one byte owed");
    wr(8'h20, cmd[DEPTH-1]);
    rd(8'h00, 8'h80, "R5 oversize clamped");
    wr(8'h00, 8'h20);
    idle(DLY + 10);
    rd(8'h01, 8'd32, "R10 burst capped");
    for (int i = 0; i < DEPTH; i++) rd(8'h40, cmd[i], "R7 full echo");
    rd(8'h00, 8'h80, "R8 drained");
    idle(2);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R2 pending reads act=%0d exp=0", exp_q.size());
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule